// File: doc/BRIEF.md
# Quad-Lane Serial Flash Transaction Sequencer

This block is the host side of a four-lane serial flash link. A single start strobe launches one of two frame types. The first is a fast quad read: an instruction byte goes out on lane 0, the address and a mode byte go out four bits per clock, a run of turnaround clocks follows with every lane released, and then data bytes arrive four bits per clock. The second is a quad-input program: the instruction and the address go out serially on lane 0, and then data bytes are sent four bits per clock.

The serial clock runs at half the system clock. Chip select falls half a serial clock before the first rising edge and rises on the last falling edge. Outputs change only on falling serial edges, and read lanes are sampled on rising ones. Write bytes are taken from a byte port as they are needed. Each received byte is presented on a one-cycle valid strobe.

Top module: `qflash_seq`

## Requirements
- R1: Under synchronous reset `cs_n_o` is 1, and `sck_o`, `io_oe_o`, `busy_o`, `rd_valid_o` and `wr_req_o` are all 0.
- R2: Every frame opens with 8 serial clocks that carry `opcode_i` MSB first on `io_o[0]`. During these clocks `io_oe_o` is 4'b0001.
- R3: When `op_read_i`=1, the address follows in 6 clocks with `io_oe_o`=4'hF. Each clock carries one nibble, bits 23..20 first and bits 3..0 last, with the nibble's highest bit on lane 3 and its lowest on lane 0.
- R4: A read frame sends the mode byte in two clocks after the address with all lanes enabled: bits 7..4 on lanes 3..0 first, then bits 3..0.
- R5: A read frame then runs DUMMY_CLKS clocks (default 4) with `io_oe_o`=0. Values on `io_i` during these clocks do not affect any received byte.
- R6: In a read frame each data byte takes two clocks with all lanes released. Lanes 3..0 are sampled at the rising serial edge, and the upper nibble comes first. `rd_valid_o` is high for exactly one cycle, the cycle right after the second rising edge, with the byte on `rd_data_o`.
- R7: When `op_read_i`=0, the 24 address bits follow the instruction MSB first on `io_o[0]` only, with `io_oe_o`=4'b0001.
- R8: In a program frame each data byte takes two clocks with `io_oe_o`=4'hF: bits 7..4 first, then bits 3..0. The byte is taken from `wr_data_i` on the edge that starts its first clock, and `wr_req_o` is high for the cycle that follows that edge.
- R9: After a start is accepted, `sck_o` is 0 for one cycle with `cs_n_o`=0, then toggles every cycle. `io_o` and `io_oe_o` change only when `sck_o` falls. On the final falling edge `cs_n_o` returns to 1 and all lanes are released.
- R10: `busy_o` is high from the cycle after an accepted start until `cs_n_o` rises. A start strobe seen while busy is ignored, and so are the parameter inputs that change with it.
- R11: A `count_i` of zero ends the frame right after the address clocks (program) or right after the turnaround clocks (read).
- R12: Data bytes follow one another without gaps, two clocks each, until exactly `count_i` bytes have moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_read_i | input | 1 | 1 = fast quad read, 0 = quad-input program |
| opcode_i | input | 8 | Instruction byte |
| addr_i | input | ADDR_W | Flash address |
| mode_i | input | 8 | Mode byte (read frames) |
| count_i | input | CNT_W | Number of data bytes |
| wr_data_i | input | 8 | Next program byte |
| wr_req_o | output | 1 | Pulse: the byte on wr_data_i has been taken |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Pulse: rd_data_o holds a new byte |
| busy_o | output | 1 | Frame in progress |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Per-lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
The bench builds the block with CNT_W=6 and the default DUMMY_CLKS=4. The narrow count field lets a read of 63 bytes run to the largest count the port can express, while the run still stays short. With four turnaround clocks, the read frame has its documented length, and garbage driven on the input lanes during that window lands on sampled edges that must not leak into the first byte. Zero counts, single bytes and start strobes raised partway through a frame cover the frame-end and ignore paths.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA
  } phase_t;

  typedef enum logic [1:0] {
    LN_OFF,
    LN_SERIAL,
    LN_QUAD
  } lane_mode_t;
endpackage

// File: rtl/qfs_phase_ctrl.sv
`timescale 1ns/1ps
module qfs_phase_ctrl
  import qfs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int DUMMY_CLKS = 4,
  parameter int PC_W       = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            op_read_i,
  input  logic [CNT_W-1:0] count_i,
  output logic            sck_o,
  output logic            cs_n_o,
  output logic            rd_mode_o,
  output phase_t          ph_o,
  output logic            cnt_odd_o,
  output logic            accept_o,
  output logic            load_o,
  output logic            rise_o,
  output logic            finish_o,
  output phase_t          load_ph_o,
  output logic [PC_W-1:0] load_cnt_o
);
  localparam int CMD_CLKS  = 8;
  localparam int QADR_CLKS = ADDR_W / 4;

  phase_t           ph_q, nph;
  logic [PC_W-1:0]  cnt_q, ncnt, data_clks;
  logic [CNT_W-1:0] bytes_q;
  logic             sck_q, cs_n_q, rd_q;
  logic             active, fall;

  assign data_clks = PC_W'({bytes_q, 1'b0}) - PC_W'(1);
  assign active    = (ph_q != PH_IDLE);
  assign fall      = active && sck_q;
  assign accept_o  = (ph_q == PH_IDLE) && start_i;
  assign rise_o    = active && !sck_q;

  always_comb begin
    nph  = ph_q;
    ncnt = cnt_q - PC_W'(1);
    if (cnt_q == '0) begin
      case (ph_q)
        PH_CMD: begin
          nph  = PH_ADDR;
          ncnt = rd_q ? PC_W'(QADR_CLKS - 1) : PC_W'(ADDR_W - 1);
        end
        PH_ADDR: begin
          if (rd_q) begin
            nph  = PH_MODE;
            ncnt = PC_W'(1);
          end else if (bytes_q == '0) begin
            nph  = PH_IDLE;
            ncnt = '0;
          end else begin
            nph  = PH_DATA;
            ncnt = data_clks;
          end
        end
        PH_MODE: begin
          nph  = PH_DUMMY;
          ncnt = PC_W'(DUMMY_CLKS - 1);
        end
        PH_DUMMY: begin
          if (bytes_q == '0) begin
            nph  = PH_IDLE;
            ncnt = '0;
          end else begin
            nph  = PH_DATA;
            ncnt = data_clks;
          end
        end
        default: begin
          nph  = PH_IDLE;
          ncnt = '0;
        end
      endcase
    end
  end

  assign load_ph_o  = accept_o ? PH_CMD : nph;
  assign load_cnt_o = accept_o ? PC_W'(CMD_CLKS - 1) : ncnt;
  assign load_o     = accept_o || (fall && nph != PH_IDLE);
  assign finish_o   = fall && (nph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      rd_q    <= 1'b0;
      bytes_q <= '0;
    end else if (accept_o) begin
      ph_q    <= PH_CMD;
      cnt_q   <= PC_W'(CMD_CLKS - 1);
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b0;
      rd_q    <= op_read_i;
      bytes_q <= count_i;
    end else if (rise_o) begin
      sck_q <= 1'b1;
    end else if (fall) begin
      sck_q <= 1'b0;
      ph_q  <= nph;
      cnt_q <= ncnt;
      if (nph == PH_IDLE) cs_n_q <= 1'b1;
    end
  end

  assign sck_o     = sck_q;
  assign cs_n_o    = cs_n_q;
  assign rd_mode_o = rd_q;
  assign ph_o      = ph_q;
  assign cnt_odd_o = cnt_q[0];
endmodule

// File: rtl/qfs_tx_drive.sv
`timescale 1ns/1ps
module qfs_tx_drive
  import qfs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PC_W   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              load_i,
  input  logic              finish_i,
  input  phase_t            load_ph_i,
  input  logic [PC_W-1:0]   load_cnt_i,
  input  logic              rd_mode_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        mode_i,
  input  logic [7:0]        wr_data_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic              wr_req_o
);
  localparam int LANES  = 4;
  localparam int NIBS   = ADDR_W / 4;
  localparam int NIB_IW = $clog2(NIBS);
  localparam int BIT_IW = $clog2(ADDR_W);

  logic [7:0]        op_q, mode_q, wb_q, op_src;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        addr_nib [NIBS];
  lane_mode_t        lmode;
  logic              ser_bit;
  logic [3:0]        quad_nib;
  logic [3:0]        nxt_io, nxt_oe;
  logic              take_byte;

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    assign addr_nib[n] = addr_q[4*n +: 4];
  end

  assign op_src = accept_i ? opcode_i : op_q;

  always_comb begin
    lmode    = LN_OFF;
    ser_bit  = 1'b0;
    quad_nib = 4'h0;
    case (load_ph_i)
      PH_CMD: begin
        lmode   = LN_SERIAL;
        ser_bit = op_src[load_cnt_i[2:0]];
      end
      PH_ADDR: begin
        if (rd_mode_i) begin
          lmode    = LN_QUAD;
          quad_nib = addr_nib[load_cnt_i[NIB_IW-1:0]];
        end else begin
          lmode   = LN_SERIAL;
          ser_bit = addr_q[load_cnt_i[BIT_IW-1:0]];
        end
      end
      PH_MODE: begin
        lmode    = LN_QUAD;
        quad_nib = load_cnt_i[0] ? mode_q[7:4] : mode_q[3:0];
      end
      PH_DATA: begin
        if (!rd_mode_i) begin
          lmode    = LN_QUAD;
          quad_nib = load_cnt_i[0] ? wr_data_i[7:4] : wb_q[3:0];
        end
      end
      default: lmode = LN_OFF;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_lane0
      assign nxt_oe[g] = (lmode != LN_OFF);
      assign nxt_io[g] = (lmode == LN_SERIAL) ? ser_bit :
                         (lmode == LN_QUAD)   ? quad_nib[g] : 1'b0;
    end else begin : g_laneN
      assign nxt_oe[g] = (lmode == LN_QUAD);
      assign nxt_io[g] = (lmode == LN_QUAD) ? quad_nib[g] : 1'b0;
    end
  end

  assign take_byte = load_i && (load_ph_i == PH_DATA) && !rd_mode_i && load_cnt_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= '0;
      mode_q   <= '0;
      addr_q   <= '0;
      wb_q     <= '0;
      io_o     <= '0;
      io_oe_o  <= '0;
      wr_req_o <= 1'b0;
    end else begin
      wr_req_o <= take_byte;
      if (accept_i) begin
        op_q   <= opcode_i;
        addr_q <= addr_i;
        mode_q <= mode_i;
      end
      if (take_byte) wb_q <= wr_data_i;
      if (load_i) begin
        io_o    <= nxt_io;
        io_oe_o <= nxt_oe;
      end else if (finish_i) begin
        io_o    <= '0;
        io_oe_o <= '0;
      end
    end
  end
endmodule

// File: rtl/qfs_rx_capture.sv
`timescale 1ns/1ps
module qfs_rx_capture
  import qfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_i,
  input  phase_t     ph_i,
  input  logic       cnt_odd_i,
  input  logic       rd_mode_i,
  input  logic [3:0] io_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o
);
  logic [3:0] hi_q;
  logic       grab;

  assign grab = rise_i && (ph_i == PH_DATA) && rd_mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      if (grab) begin
        if (cnt_odd_i) begin
          hi_q <= io_i;
        end else begin
          rd_data_o  <= {hi_q, io_i};
          rd_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qflash_seq.sv
`timescale 1ns/1ps
module qflash_seq
  import qfs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int DUMMY_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_read_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [7:0]        wr_data_i,
  output logic              wr_req_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);
  localparam int W_CNT  = CNT_W + 1;
  localparam int W_ADR  = $clog2(ADDR_W) + 1;
  localparam int W_DMY  = $clog2(DUMMY_CLKS) + 1;
  localparam int W_AB   = (W_CNT > W_ADR) ? W_CNT : W_ADR;
  localparam int PC_W   = (W_AB > W_DMY) ? W_AB : W_DMY;

  phase_t          ph, load_ph;
  logic [PC_W-1:0] load_cnt;
  logic            rd_mode, cnt_odd, accept, load, rise, finish;

  qfs_phase_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_CLKS(DUMMY_CLKS), .PC_W(PC_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .op_read_i(op_read_i),
    .count_i(count_i), .sck_o(sck_o), .cs_n_o(cs_n_o), .rd_mode_o(rd_mode),
    .ph_o(ph), .cnt_odd_o(cnt_odd), .accept_o(accept), .load_o(load),
    .rise_o(rise), .finish_o(finish), .load_ph_o(load_ph), .load_cnt_o(load_cnt)
  );

  qfs_tx_drive #(
    .ADDR_W(ADDR_W), .PC_W(PC_W)
  ) u_tx (
    .clk(clk), .rst(rst), .accept_i(accept), .load_i(load), .finish_i(finish),
    .load_ph_i(load_ph), .load_cnt_i(load_cnt), .rd_mode_i(rd_mode),
    .opcode_i(opcode_i), .addr_i(addr_i), .mode_i(mode_i), .wr_data_i(wr_data_i),
    .io_o(io_o), .io_oe_o(io_oe_o), .wr_req_o(wr_req_o)
  );

  qfs_rx_capture u_rx (
    .clk(clk), .rst(rst), .rise_i(rise), .ph_i(ph), .cnt_odd_i(cnt_odd),
    .rd_mode_i(rd_mode), .io_i(io_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  assign busy_o = ~cs_n_o;
endmodule

// File: rtl/qflash_seq_chk.sv
`timescale 1ns/1ps
module qflash_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       cs_n_o,
  input logic       sck_o,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       rd_valid_o,
  input logic       wr_req_o
);
  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (!sck_o && io_oe_o == 4'h0));

  assert_sck_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !$past(cs_n_o)) |-> (sck_o != $past(sck_o)));

  assert_hold_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> ($stable(io_o) && $stable(io_oe_o)));

  assert_lane_set_R2: assert property (@(posedge clk) disable iff (rst)
    (io_oe_o == 4'h0 || io_oe_o == 4'h1 || io_oe_o == 4'hF));

  assert_rdv_single_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |=> !rd_valid_o);

  assert_rdv_released_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (io_oe_o == 4'h0 && sck_o));

  assert_wrreq_quad_R8: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |-> (io_oe_o == 4'hF && !sck_o));

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind qflash_seq qflash_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
  .sck_o(sck_o), .io_o(io_o), .io_oe_o(io_oe_o), .rd_valid_o(rd_valid_o),
  .wr_req_o(wr_req_o)
);

// File: tb/qflash_seq_bench.sv
`timescale 1ns/1ps
module qflash_seq_bench;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 6;
  localparam int DUMMY  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0, op_read_i = 1'b0;
  logic [7:0]        opcode_i = '0, mode_i = '0, wr_data_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic [3:0]        io_i = '0;
  logic              wr_req_o, rd_valid_o, busy_o, sck_o, cs_n_o;
  logic [7:0]        rd_data_o;
  logic [3:0]        io_o, io_oe_o;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  qflash_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_CLKS(DUMMY)) u_qflash_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .op_read_i(op_read_i),
    .opcode_i(opcode_i), .addr_i(addr_i), .mode_i(mode_i), .count_i(count_i),
    .wr_data_i(wr_data_i), .wr_req_o(wr_req_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .busy_o(busy_o), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: per serial clock, the lane enables, lane values, the input
  // nibble offered, the requirement covered, and byte-event markers.
  task automatic run_frame(input bit rd, input logic [7:0] op, input logic [23:0] ad,
                           input logic [7:0] md, input int cnt, input bit poke);
    logic [3:0] l_oe[$], l_io[$], l_in[$];
    bit         l_wr[$], l_rv[$];
    string      l_req[$];
    logic [7:0] wb[$], rb[$];
    int         n, wptr, rptr, seen;
    string      dreq, endreq;
    for (int i = 7; i >= 0; i--) begin
      l_oe.push_back(4'h1); l_io.push_back({3'b0, op[i]}); l_in.push_back(4'(i ^ 5));
      l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R2");
    end
    if (rd) begin
      for (int k = 5; k >= 0; k--) begin
        l_oe.push_back(4'hF); l_io.push_back(ad[4*k +: 4]); l_in.push_back(4'hC);
        l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R3");
      end
      l_oe.push_back(4'hF); l_io.push_back(md[7:4]); l_in.push_back(4'h3);
      l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R4");
      l_oe.push_back(4'hF); l_io.push_back(md[3:0]); l_in.push_back(4'h6);
      l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R4");
      for (int k = 0; k < DUMMY; k++) begin
        l_oe.push_back(4'h0); l_io.push_back(4'h0); l_in.push_back(4'(4'hA ^ k));
        l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R5");
      end
      for (int b = 0; b < cnt; b++) begin
        logic [7:0] v;
        v = 8'(b * 53 + 7 + ad[7:0]);
        rb.push_back(v);
        dreq = (b == 0) ? "R6" : "R12";
        l_oe.push_back(4'h0); l_io.push_back(4'h0); l_in.push_back(v[7:4]);
        l_wr.push_back(0); l_rv.push_back(0); l_req.push_back(dreq);
        l_oe.push_back(4'h0); l_io.push_back(4'h0); l_in.push_back(v[3:0]);
        l_wr.push_back(0); l_rv.push_back(1); l_req.push_back(dreq);
      end
    end else begin
      for (int i = 23; i >= 0; i--) begin
        l_oe.push_back(4'h1); l_io.push_back({3'b0, ad[i]}); l_in.push_back(4'h9);
        l_wr.push_back(0); l_rv.push_back(0); l_req.push_back("R7");
      end
      for (int b = 0; b < cnt; b++) begin
        logic [7:0] v;
        v = 8'(b * 37 + 11 + op);
        wb.push_back(v);
        dreq = (b == 0) ? "R8" : "R12";
        l_oe.push_back(4'hF); l_io.push_back(v[7:4]); l_in.push_back(4'h0);
        l_wr.push_back(1); l_rv.push_back(0); l_req.push_back(dreq);
        l_oe.push_back(4'hF); l_io.push_back(v[3:0]); l_in.push_back(4'h0);
        l_wr.push_back(0); l_rv.push_back(0); l_req.push_back(dreq);
      end
    end
    n = l_oe.size();
    endreq = (cnt == 0) ? "R11" : "R9";
    wptr = 1; rptr = 0; seen = 0;
    wr_data_i = (wb.size() > 0) ? wb[0] : 8'h00;
    @(negedge clk);
    start_i = 1'b1; op_read_i = rd; opcode_i = op; addr_i = ad; mode_i = md;
    count_i = CNT_W'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= 2 * n; k++) begin
      if (k < 2 * n) begin
        int  j;
        bit  ph;
        bit  ev;
        j  = k / 2;
        ph = (k % 2) == 1;
        chk(cs_n_o == 1'b0 && sck_o == ph, "R9", {cs_n_o, sck_o}, {1'b0, ph});
        chk(busy_o == 1'b1, poke ? "R10" : "R9", busy_o, 1);
        chk(io_oe_o == l_oe[j], l_req[j], io_oe_o, l_oe[j]);
        chk((io_o & l_oe[j]) == (l_io[j] & l_oe[j]), l_req[j], io_o & l_oe[j], l_io[j] & l_oe[j]);
        ev = l_wr[j] && !ph;
        chk(wr_req_o == ev, l_req[j], wr_req_o, ev);
        ev = l_rv[j] && ph;
        chk(rd_valid_o == ev, l_req[j], rd_valid_o, ev);
        if (ev) begin
          chk(rd_data_o == rb[rptr], l_req[j], rd_data_o, rb[rptr]);
          rptr++;
        end
        if (rd_valid_o) seen++;
        if (wr_req_o) begin
          wr_data_i = (wptr < wb.size()) ? wb[wptr] : 8'hEE;
          wptr++;
        end
        if (!ph) io_i = l_in[j];
        if (poke && k == 5) begin
          start_i = 1'b1; op_read_i = !rd; opcode_i = ~op; addr_i = ~ad; mode_i = ~md;
          count_i = '1;
        end
        if (poke && k == 7) start_i = 1'b0;
        @(negedge clk);
      end else begin
        chk(cs_n_o == 1'b1 && sck_o == 1'b0 && io_oe_o == 4'h0, endreq,
            {cs_n_o, sck_o, io_oe_o}, 6'b100000);
        chk(busy_o == 1'b0, "R10", busy_o, 0);
      end
    end
    chk(seen == (rd ? cnt : 0), "R12", seen, rd ? cnt : 0);
    chk(wptr - 1 == (rd ? 0 : cnt), "R12", wptr - 1, rd ? 0 : cnt);
    io_i = '0;
    @(negedge clk);
    chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R10", {cs_n_o, busy_o}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n_o == 1'b1, "R1", cs_n_o, 1);
    chk(sck_o == 1'b0 && io_oe_o == 4'h0, "R1", {sck_o, io_oe_o}, 0);
    chk(busy_o == 1'b0 && rd_valid_o == 1'b0 && wr_req_o == 1'b0, "R1",
        {busy_o, rd_valid_o, wr_req_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    run_frame(1'b1, 8'hEB, 24'h5A3C91, 8'hA5, 3, 1'b0);
    run_frame(1'b0, 8'h32, 24'h123456, 8'h00, 2, 1'b0);
    run_frame(1'b1, 8'h6B, 24'hF0F00F, 8'h3C, 0, 1'b0);
    run_frame(1'b0, 8'h38, 24'h800001, 8'h00, 0, 1'b0);
    run_frame(1'b1, 8'hEB, 24'hC3A596, 8'h5A, 63, 1'b0);
    run_frame(1'b0, 8'h32, 24'h0FEDCB, 8'h00, 5, 1'b1);
    run_frame(1'b1, 8'hE7, 24'h000000, 8'hFF, 1, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule